// File: doc/BRIEF.md
# Alarm and Countdown Timer Interrupt Unit

This block watches the current calendar time and raises an alarm when the minute, hour, day and weekday fields equal their programmed values. Each alarm field can be left out of the comparison. It also runs an 8-bit periodic countdown timer. The timer takes its count pulses from one of four external clock taps, selected by software. Each function owns a sticky flag in a control byte. Software clears a flag by writing that byte: the written value is ANDed into the flags, so a 0 clears a flag and a 1 leaves it unchanged.

One interrupt line merges the two sources, each gated by its own enable. The timer source can drive the line in two ways. In level mode the line follows the timer flag. In pulse mode the line gives a single-cycle pulse at every terminal count. Software reaches the block through a simple register port: a write strobe, an address, write data, and a combinational read back. Calendar counting and the serial bus are handled outside this block.

Top module: `almtmr_irq`

Register map (byte registers):
- 0: control. Bit 4 selects pulse mode. Bit 3 is the alarm flag. Bit 2 is the timer flag. Bit 1 enables the alarm interrupt. Bit 0 enables the timer interrupt.
- 1 to 4: alarm minute, alarm hour, alarm day, alarm weekday, all in BCD. Bit 7 of each is a disable bit.
- 5: timer control. Bit 7 enables the timer. Bits 1:0 select the tap.
- 6: timer value.

## Requirements
- R1: After reset the registers read as follows: register 0 reads 0x00, registers 1 to 4 read 0x80, register 5 reads 0x03 and register 6 reads 0x00. After reset `irqDrive` is 0.
- R2: The alarm flag (register 0, bit 3) sets when every enabled alarm field equals its time input. Fields are compared on masked bits: 6:0 for the minute, 5:0 for the hour and the day, 2:0 for the weekday. Upper input bits are ignored.
- R3: An alarm field whose bit 7 is 1 is left out of the comparison. When all four fields are disabled, the alarm flag never sets.
- R4: The alarm flag sets only on the cycle where the match begins. If software clears the flag while the match persists, the flag stays clear until the match ends and starts again.
- R5: A write to register 0 ANDs data bits 3 and 2 into the alarm and timer flags. The same write loads bits 4, 1 and 0 directly. If a flag sets in the same cycle as a clearing write, the set wins.
- R6: The timer advances only on a pulse of the tap selected by register 5, bits 1:0. The encodings are 00 `tickFast`, 01 `tick64Hz`, 10 `tickSec` and 11 `tickMinute`.
- R7: A selected tick that arrives when the count is 1 does three things: it sets the timer flag (register 0, bit 2), reloads the count from the value last written, and lets counting continue.
- R8: A write to register 6 loads both the reload value and the live count. A read of register 6 returns the live count.
- R9: While the reload value is 0, the timer does not count and does not set the timer flag.
- R10: `irqDrive` is the alarm flag ANDed with register 0 bit 1, ORed with the timer source ANDed with register 0 bit 0. With both enables 0, `irqDrive` stays 0.
- R11: In level mode (register 0, bit 4 = 0) the timer source is the timer flag. In pulse mode the timer source is a one-cycle pulse. In both modes the interrupt rises in the same cycle as the timer flag.
- R12: While register 5 bit 7 is 0, the count holds even when the selected tap pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| curMin | input | 8 | Current minute, BCD |
| curHour | input | 8 | Current hour, BCD |
| curDay | input | 8 | Current day of month, BCD |
| curWday | input | 8 | Current weekday |
| tickFast | input | 1 | Fastest timer tap, one-cycle strobe |
| tick64Hz | input | 1 | 64 Hz timer tap strobe |
| tickSec | input | 1 | 1 Hz timer tap strobe |
| tickMinute | input | 1 | Once-per-minute timer tap strobe |
| irqDrive | output | 1 | High when the interrupt line is pulled active |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, a 3-bit address and four taps. Every tap is an input strobe, so the bench can fire a once-per-minute tick as easily as the fastest tap. This puts all four source selections, the terminal-count reload and both interrupt modes within reach in a few dozen cycles. A table of time vectors walks the alarm through matches that begin, persist, break and return, including masked upper input bits.

// File: rtl/almtmr_pkg.sv
package almtmr_pkg;
  localparam int REG_CTRL    = 0;
  localparam int REG_ALM0    = 1;
  localparam int REG_TMR_CTL = 5;
  localparam int REG_TMR_VAL = 6;

  localparam int BIT_PULSE = 4;
  localparam int BIT_AF    = 3;
  localparam int BIT_TF    = 2;
  localparam int BIT_AIE   = 1;
  localparam int BIT_TIE   = 0;

  localparam int NUM_FIELDS = 4;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrAlarm;
    logic                  wrTmrCtl;
    logic                  wrTmrVal;
  } dpStrobe_t;

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      0:       return 8'h7F;
      1, 2:    return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/almtmr_ctrl.sv
module almtmr_ctrl
  import almtmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              almMatch,
  input  logic              tmrExpire,
  output dpStrobe_t         stb,
  output logic [DATA_W-1:0] ctrlByte,
  output logic              irqDrive
);
  logic afFlag, tfFlag, aie, tie, pulseMode, matchPrev, pulseReg;
  logic wrCtrl;

  assign wrCtrl = wrEn && (addr == ADDR_W'(REG_CTRL));

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm_stb
    assign stb.wrAlarm[i] = wrEn && (addr == ADDR_W'(REG_ALM0 + i));
  end
  assign stb.wrTmrCtl = wrEn && (addr == ADDR_W'(REG_TMR_CTL));
  assign stb.wrTmrVal = wrEn && (addr == ADDR_W'(REG_TMR_VAL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      afFlag    <= 1'b0;
      tfFlag    <= 1'b0;
      aie       <= 1'b0;
      tie       <= 1'b0;
      pulseMode <= 1'b0;
      matchPrev <= 1'b0;
      pulseReg  <= 1'b0;
    end else begin
      matchPrev <= almMatch;
      pulseReg  <= tmrExpire;
      afFlag    <= (almMatch & ~matchPrev) | (afFlag & ~(wrCtrl & ~wrData[BIT_AF]));
      tfFlag    <= tmrExpire | (tfFlag & ~(wrCtrl & ~wrData[BIT_TF]));
      if (wrCtrl) begin
        pulseMode <= wrData[BIT_PULSE];
        aie       <= wrData[BIT_AIE];
        tie       <= wrData[BIT_TIE];
      end
    end
  end

  always_comb begin
    ctrlByte            = '0;
    ctrlByte[BIT_PULSE] = pulseMode;
    ctrlByte[BIT_AF]    = afFlag;
    ctrlByte[BIT_TF]    = tfFlag;
    ctrlByte[BIT_AIE]   = aie;
    ctrlByte[BIT_TIE]   = tie;
  end

  assign irqDrive = (aie & afFlag) | (tie & (pulseMode ? pulseReg : tfFlag));
endmodule

// File: rtl/almtmr_dp.sv
module almtmr_dp
  import almtmr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_TAPS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    stb,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [NUM_FIELDS*DATA_W-1:0] curTime,
  input  logic [NUM_TAPS-1:0]          taps,
  input  logic [DATA_W-1:0]            ctrlByte,
  output logic                         almMatch,
  output logic                         tmrExpire,
  output logic [DATA_W-1:0]            rdData
);
  localparam int SEL_W = $clog2(NUM_TAPS);
  localparam int DIS_BIT = DATA_W - 1;

  logic [DATA_W-1:0]     almReg [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldHit, fieldOn;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [DATA_W-1:0] MASK = DATA_W'(fieldMask(i));
    always_ff @(posedge clk) begin
      if (!rstN)                almReg[i] <= DATA_W'(1) << DIS_BIT;
      else if (stb.wrAlarm[i])  almReg[i] <= wrData;
    end
    assign fieldOn[i]  = ~almReg[i][DIS_BIT];
    assign fieldHit[i] = almReg[i][DIS_BIT] |
                         ((curTime[i*DATA_W +: DATA_W] & MASK) == (almReg[i] & MASK));
  end

  assign almMatch = (&fieldHit) & (|fieldOn);

  logic              tmrEn;
  logic [SEL_W-1:0]  tmrSel;
  logic [DATA_W-1:0] rld, cnt;
  logic              advance;

  assign advance   = tmrEn && taps[tmrSel] && (rld != '0) && (cnt != '0) && !stb.wrTmrVal;
  assign tmrExpire = advance && (cnt == DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrEn  <= 1'b0;
      tmrSel <= '1;
      rld    <= '0;
      cnt    <= '0;
    end else begin
      if (stb.wrTmrCtl) begin
        tmrEn  <= wrData[DIS_BIT];
        tmrSel <= wrData[SEL_W-1:0];
      end
      if (stb.wrTmrVal) begin
        rld <= wrData;
        cnt <= wrData;
      end else if (advance) begin
        cnt <= (cnt == DATA_W'(1)) ? rld : cnt - DATA_W'(1);
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(REG_CTRL)) rdData = ctrlByte;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr == ADDR_W'(REG_ALM0 + i)) rdData = almReg[i];
    if (addr == ADDR_W'(REG_TMR_CTL)) begin
      rdData                 = '0;
      rdData[DIS_BIT]        = tmrEn;
      rdData[SEL_W-1:0]      = tmrSel;
    end
    if (addr == ADDR_W'(REG_TMR_VAL)) rdData = cnt;
  end
endmodule

// File: rtl/almtmr_irq.sv
module almtmr_irq
  import almtmr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_TAPS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDay,
  input  logic [DATA_W-1:0] curWday,
  input  logic              tickFast,
  input  logic              tick64Hz,
  input  logic              tickSec,
  input  logic              tickMinute,
  output logic              irqDrive
);
  dpStrobe_t         stb;
  logic              almMatch, tmrExpire;
  logic [DATA_W-1:0] ctrlByte;
  logic [NUM_TAPS-1:0] taps;

  assign taps = NUM_TAPS'({tickMinute, tickSec, tick64Hz, tickFast});

  almtmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .almMatch(almMatch), .tmrExpire(tmrExpire), .stb(stb),
    .ctrlByte(ctrlByte), .irqDrive(irqDrive)
  );

  almtmr_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_TAPS(NUM_TAPS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .curTime({curWday, curDay, curHour, curMin}), .taps(taps),
    .ctrlByte(ctrlByte), .almMatch(almMatch), .tmrExpire(tmrExpire),
    .rdData(rdData)
  );
endmodule

// File: rtl/almtmr_chk.sv
module almtmr_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqDrive,
  input logic              almMatch,
  input logic              tmrExpire,
  input logic [DATA_W-1:0] ctrlByte
);
  // R10
  no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[1:0] == 2'b00) |-> !irqDrive);
  // R2
  af_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlByte[3]) |-> $past(almMatch));
  // R11
  tf_irq_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlByte[2]) && ctrlByte[0]) |-> irqDrive);
  // R5
  flag_and_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0 && !wrData[2] && !tmrExpire) |=> !ctrlByte[2]);
  // R7
  expire_sets_tf_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrExpire |=> ctrlByte[2]);
endmodule

bind almtmr_irq almtmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irqDrive(irqDrive), .almMatch(almMatch), .tmrExpire(tmrExpire),
  .ctrlByte(ctrlByte)
);

// File: tb/tb_almtmr_irq.sv
module tb_almtmr_irq;
  logic clk = 0, rstN = 0, wrEn = 0;
  logic [2:0] addr = 0;
  logic [7:0] wrData = 0, rdData;
  logic [7:0] curMin = 0, curHour = 0, curDay = 0, curWday = 0;
  logic tickFast = 0, tick64Hz = 0, tickSec = 0, tickMinute = 0;
  logic irqDrive;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  almtmr_irq dut (.*);

  // {min, hour, day, wday, expected alarm flag}
  localparam logic [39:0] VEC [9] = '{
    {8'h29, 8'h12, 8'h01, 8'h00, 8'h00},
    {8'h30, 8'h12, 8'h01, 8'h00, 8'h01},
    {8'h30, 8'h12, 8'h01, 8'h00, 8'h00},
    {8'h30, 8'h13, 8'h01, 8'h00, 8'h00},
    {8'h30, 8'h12, 8'h01, 8'h00, 8'h01},
    {8'h30, 8'h12, 8'h05, 8'h03, 8'h00},
    {8'h31, 8'h12, 8'h05, 8'h03, 8'h00},
    {8'hB0, 8'hD2, 8'h05, 8'h03, 8'h01},
    {8'h30, 8'h11, 8'h05, 8'h03, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic pulseTap(input int which);
    @(negedge clk);
    case (which)
      0: tickFast = 1;
      1: tick64Hz = 1;
      2: tickSec = 1;
      default: tickMinute = 1;
    endcase
    @(negedge clk);
    tickFast = 0; tick64Hz = 0; tickSec = 0; tickMinute = 0;
  endtask

  task automatic setTime(input logic [7:0] m, input logic [7:0] h);
    @(negedge clk); curMin = m; curHour = h;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1", v, (a == 0 || a == 6) ? 8'h00 : (a == 5) ? 8'h03 : 8'h80);
    end
    check("R1 irq", {7'b0, irqDrive}, 8'h00);

    // alarm: minute 30 and hour 12 enabled, day and weekday disabled
    wr(3'd1, 8'h30); wr(3'd2, 8'h12); wr(3'd3, 8'h81); wr(3'd4, 8'h80);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      curMin = VEC[i][39:32]; curHour = VEC[i][31:24];
      curDay = VEC[i][23:16]; curWday = VEC[i][15:8];
      repeat (2) @(negedge clk);
      rd(3'd0, v);
      check("R2/R3/R4 table", {7'b0, v[3]}, VEC[i][7:0]);
      check("R10 no enables", {7'b0, irqDrive}, 8'h00);
      wr(3'd0, 8'h00);
    end

    // R10 alarm interrupt with AIE
    wr(3'd0, 8'h02);
    setTime(8'h30, 8'h12);
    rd(3'd0, v); check("R2 flag", v, 8'h0A);
    check("R10 alarm irq", {7'b0, irqDrive}, 8'h01);
    // R5 write 1 keeps AF, write 0 clears
    wr(3'd0, 8'h0A); rd(3'd0, v); check("R5 keep", v, 8'h0A);
    wr(3'd0, 8'h02); rd(3'd0, v); check("R5 clear", v, 8'h02);
    check("R4 persist no irq", {7'b0, irqDrive}, 8'h00);

    // R3 all fields disabled
    wr(3'd1, 8'hB0); wr(3'd2, 8'h92);
    setTime(8'h31, 8'h12); setTime(8'h30, 8'h12);
    rd(3'd0, v); check("R3 all disabled", v, 8'h02);

    // timer, 64 Hz tap, level mode
    wr(3'd0, 8'h01); wr(3'd6, 8'h03); wr(3'd5, 8'h81);
    rd(3'd5, v); check("R6 ctl readback", v, 8'h81);
    rd(3'd6, v); check("R8 load", v, 8'h03);
    pulseTap(1); rd(3'd6, v); check("R8 live count", v, 8'h02);
    pulseTap(0); rd(3'd6, v); check("R6 unselected tap", v, 8'h02);
    pulseTap(1); pulseTap(1);
    rd(3'd6, v); check("R7 reload", v, 8'h03);
    rd(3'd0, v); check("R7 TF", v, 8'h05);
    check("R11 level irq", {7'b0, irqDrive}, 8'h01);
    wr(3'd0, 8'h01); rd(3'd0, v); check("R5 clear TF", v, 8'h01);
    check("R11 level follows", {7'b0, irqDrive}, 8'h00);

    // pulse mode
    wr(3'd0, 8'h11);
    pulseTap(1); pulseTap(1);
    @(negedge clk); tick64Hz = 1;
    @(negedge clk); tick64Hz = 0;
    check("R11 pulse high", {7'b0, irqDrive}, 8'h01);
    @(negedge clk);
    check("R11 pulse low", {7'b0, irqDrive}, 8'h00);
    rd(3'd0, v); check("R7 TF pulse mode", v, 8'h15);
    wr(3'd0, 8'h15); rd(3'd0, v); check("R5 keep TF", v, 8'h15);
    wr(3'd0, 8'h11);

    // R12 timer disabled holds
    wr(3'd5, 8'h01);
    pulseTap(1); rd(3'd6, v); check("R12 hold", v, 8'h03);
    // R6 once-per-minute tap
    wr(3'd5, 8'h83);
    pulseTap(1); rd(3'd6, v); check("R6 slow ignores 64", v, 8'h03);
    pulseTap(3); rd(3'd6, v); check("R6 slow tap", v, 8'h02);
    wr(3'd5, 8'h82);
    pulseTap(2); rd(3'd6, v); check("R6 second tap", v, 8'h01);
    // R9 reload zero
    wr(3'd6, 8'h00); wr(3'd5, 8'h83);
    pulseTap(3); pulseTap(3);
    rd(3'd6, v); check("R9 count", v, 8'h00);
    rd(3'd0, v); check("R9 no TF", v, 8'h11);
    check("R9 no irq", {7'b0, irqDrive}, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule